// File: doc/BRIEF.md
# RMII receive data formatter

This block sits between a receive FIFO filled by the PHY's line decoder and the RMII receive pins of a MAC. It reads whole bytes from a show-ahead FIFO and turns each one into a stream of 2-bit di-bits, driven once per di-bit period on `rxd_o`. The period is one reference-clock cycle at 100 Mb/s and ten reference-clock cycles at 10 Mb/s. It also drives the combined carrier-sense/data-valid output `crs_dv_o`.

A frame opens with a start marker of `01` as soon as carrier is seen. Buffered bytes follow, lowest di-bit first. When carrier goes away while bytes are still buffered, `crs_dv_o` alternates low and high on successive di-bits until the buffer runs dry. A false carrier or a symbol error replaces the data with the error code `10` for as long as carrier lasts. Carrier detection, false-carrier and symbol-error flags come in as inputs from the line decoder.

Top module: `rmii_rx_fmt`

## Requirements
- R1: During reset (asynchronous, active low) and whenever the interface is idle, `rxd_o` is `00` and `crs_dv_o` is 0. No FIFO read is issued while idle, even when the FIFO holds data.
- R2: On the first clock edge at which `carrier_i` is high while idle, with both error flags low, `crs_dv_o` rises and `rxd_o` shows the start marker `01` for one di-bit period.
- R3: Each FIFO byte is sent as four di-bits, bits [1:0] first and bits [7:6] last. The FIFO is show-ahead: `fifo_data_i` is valid while `fifo_empty_i` is 0, and a one-cycle `fifo_rd_o` pulse consumes it. Exactly one read is issued per byte sent.
- R4: At 100 Mb/s (`speed_10_i` = 0), consecutive di-bits of a frame, across byte borders, appear on consecutive clock cycles.
- R5: At 10 Mb/s (`speed_10_i` = 1), every di-bit of a frame, the start marker included, is held for exactly 10 clock cycles.
- R6: `speed_10_i` is sampled only while idle, up to and including the edge that starts a frame. A change during a frame has no effect on that frame's pacing.
- R7: Carrier is sampled at di-bit boundaries. Slots are counted from the start marker (slot 0), and even-numbered slots are the first of a pair. Once carrier has been seen low, carrier is ignored until idle. Each further di-bit taken from buffered data has `crs_dv_o` at 0 in even slots and at 1 in odd slots.
- R8: At the first boundary where carrier has been lost and no data remains (shifter and FIFO empty), the block returns to idle.
- R9: While carrier is present but no data is available, `rxd_o` is `00` and `crs_dv_o` stays 1.
- R10: If `false_carrier_i` or `symbol_err_i` is high at the edge that starts a frame, `rxd_o` is `10` and `crs_dv_o` is 1 until a boundary finds carrier low, and then the block goes idle. No FIFO read is issued meanwhile.
- R11: If `symbol_err_i` is high at a boundary inside a frame while carrier is still present, the next slot and all later ones show `10` with `crs_dv_o` at 1 until carrier is low at a boundary. The rest of the current byte is dropped, and the FIFO is not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed_10_i | input | 1 | 1 selects 10 Mb/s pacing, 0 selects 100 Mb/s |
| carrier_i | input | 1 | Medium non-idle flag from the line decoder |
| false_carrier_i | input | 1 | False carrier detected for this activity |
| symbol_err_i | input | 1 | Symbol error detected |
| fifo_empty_i | input | 1 | Receive FIFO empty |
| fifo_data_i | input | DATA_W | Head byte of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop strobe for the FIFO head |
| rxd_o | output | 2 | Receive di-bit |
| crs_dv_o | output | 1 | Carrier sense / receive data valid |

## Verification
Both outputs are registered. A level applied on a falling edge is acted on at the next rising edge and can be seen at the falling edge after that. Carrier and error flags have an effect only at a di-bit boundary, so the bench drives them on a falling edge inside the slot before the boundary it targets. It then checks the following slot on each of that slot's falling edges: one edge at 100 Mb/s and all ten at 10 Mb/s. This confirms both the value and that it holds for the whole slot. FIFO reads are checked through the bench FIFO's pointers after each frame, so a missing or extra pop shows up even when the di-bits look right.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_ERR  = 2'd2
  } rx_state_e;

  localparam logic [1:0] DIB_QUIET = 2'b00;
  localparam logic [1:0] DIB_START = 2'b01;
  localparam logic [1:0] DIB_ERR   = 2'b10;
endpackage

// File: rtl/rmii_rx_pace.sv
module rmii_rx_pace #(
  parameter int unsigned DIV_SLOW = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic speed_10_i,
  output logic slot_end_o,
  output logic phase_o
);
  localparam int unsigned CW = $clog2(DIV_SLOW);
  localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);

  logic          slow_q;
  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic [CW-1:0] last;

  assign last       = slow_q ? LAST_SLOW : '0;
  assign slot_end_o = active_i && (cnt_q == last);
  assign phase_o    = phase_q;

  // speed latch: open only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slow_q <= 1'b0;
    else if (!active_i) slow_q <= speed_10_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (slot_end_o) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  p_speed_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> $stable(slow_q));
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_SLOW);
  p_fast_every_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !slow_q) |-> slot_end_o);
endmodule

// File: rtl/rmii_rx_shift.sv
module rmii_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic              avail_o,
  output logic [1:0]        dibit_o
);
  localparam int unsigned NDIB = DATA_W / 2;
  localparam int unsigned RW   = $clog2(NDIB + 1);

  logic [DATA_W-1:0] sh_q;
  logic [RW-1:0]     rem_q;
  logic              held;

  assign held      = (rem_q != '0);
  assign avail_o   = held || !fifo_empty_i;
  assign dibit_o   = held ? sh_q[1:0] : fifo_data_i[1:0];
  assign fifo_rd_o = adv_i && !held && !fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (clr_i) begin
      rem_q <= '0;
    end else if (adv_i) begin
      if (held) begin
        sh_q  <= sh_q >> 2;
        rem_q <= rem_q - RW'(1);
      end else if (!fifo_empty_i) begin
        sh_q  <= fifo_data_i >> 2;
        rem_q <= RW'(NDIB - 1);
      end
    end
  end

  p_adv_has_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> avail_o);
  p_rem_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= RW'(NDIB - 1));
  p_pop_starts_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_o && !clr_i) |=> (rem_q == RW'(NDIB - 1)));
endmodule

// File: rtl/rmii_rx_seq.sv
module rmii_rx_seq
  import rmii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       carrier_i,
  input  logic       false_carrier_i,
  input  logic       symbol_err_i,
  input  logic       slot_end_i,
  input  logic       phase_i,
  input  logic       avail_i,
  input  logic [1:0] dibit_i,
  output logic       adv_o,
  output logic       active_o,
  output logic       clr_o,
  output logic [1:0] rxd_o,
  output logic       crs_dv_o
);
  rx_state_e  state_q, state_d;
  logic [1:0] rxd_q, rxd_d;
  logic       crs_q, crs_d;
  logic       lost_q, lost_d;
  logic       lost_now;

  assign lost_now = lost_q || !carrier_i;

  always_comb begin
    state_d = state_q;
    rxd_d   = rxd_q;
    crs_d   = crs_q;
    lost_d  = lost_q;
    adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        rxd_d  = DIB_QUIET;
        crs_d  = 1'b0;
        lost_d = 1'b0;
        if (carrier_i) begin
          crs_d = 1'b1;
          if (false_carrier_i || symbol_err_i) begin
            state_d = ST_ERR;
            rxd_d   = DIB_ERR;
          end else begin
            state_d = ST_DATA;
            rxd_d   = DIB_START;
          end
        end
      end
      ST_DATA: begin
        if (slot_end_i) begin
          lost_d = lost_now;
          if (!lost_now && symbol_err_i) begin
            state_d = ST_ERR;
            rxd_d   = DIB_ERR;
            crs_d   = 1'b1;
          end else if (avail_i) begin
            adv_o = 1'b1;
            rxd_d = dibit_i;
            // after carrier loss: high only on the second slot of a pair
            crs_d = !lost_now || !phase_i;
          end else if (lost_now) begin
            state_d = ST_IDLE;
            rxd_d   = DIB_QUIET;
            crs_d   = 1'b0;
          end else begin
            rxd_d = DIB_QUIET;
            crs_d = 1'b1;
          end
        end
      end
      ST_ERR: begin
        if (slot_end_i && !carrier_i) begin
          state_d = ST_IDLE;
          rxd_d   = DIB_QUIET;
          crs_d   = 1'b0;
        end
      end
      default: begin
        state_d = ST_IDLE;
        rxd_d   = DIB_QUIET;
        crs_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rxd_q   <= DIB_QUIET;
      crs_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rxd_q   <= rxd_d;
      crs_q   <= crs_d;
      lost_q  <= lost_d;
    end
  end

  assign active_o = (state_q != ST_IDLE);
  assign clr_o    = (state_q != ST_DATA);
  assign rxd_o    = rxd_q;
  assign crs_dv_o = crs_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (rxd_q == DIB_QUIET && !crs_q));
  p_start_marker_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && carrier_i && !false_carrier_i && !symbol_err_i)
      |=> (rxd_q == DIB_START && crs_q));
  p_carrier_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !lost_q) |-> crs_q);
  p_drain_first_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && lost_q && slot_end_i && avail_i && phase_i) |=> !crs_q);
  p_err_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR) |-> (rxd_q == DIB_ERR && crs_q));
  p_err_no_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR) |-> !adv_o);
endmodule

// File: rtl/rmii_rx_fmt.sv
module rmii_rx_fmt #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_SLOW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              speed_10_i,
  input  logic              carrier_i,
  input  logic              false_carrier_i,
  input  logic              symbol_err_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic [1:0]        rxd_o,
  output logic              crs_dv_o
);
  logic       slot_end, phase, active, clr, adv, avail;
  logic [1:0] dibit;

  rmii_rx_pace #(.DIV_SLOW(DIV_SLOW)) u_pace (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .speed_10_i (speed_10_i),
    .slot_end_o (slot_end),
    .phase_o    (phase)
  );

  rmii_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .adv_i        (adv),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_rd_o    (fifo_rd_o),
    .avail_o      (avail),
    .dibit_o      (dibit)
  );

  rmii_rx_seq u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .carrier_i       (carrier_i),
    .false_carrier_i (false_carrier_i),
    .symbol_err_i    (symbol_err_i),
    .slot_end_i      (slot_end),
    .phase_i         (phase),
    .avail_i         (avail),
    .dibit_i         (dibit),
    .adv_o           (adv),
    .active_o        (active),
    .clr_o           (clr),
    .rxd_o           (rxd_o),
    .crs_dv_o        (crs_dv_o)
  );

  p_idle_no_pop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !fifo_rd_o);
endmodule

// File: tb/rmii_rx_fmt_bench.sv
module rmii_rx_fmt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_10 = 1'b0;
  logic       carrier = 1'b0;
  logic       false_car = 1'b0;
  logic       sym_err = 1'b0;
  logic       fifo_empty;
  logic [7:0] fifo_data;
  logic       fifo_rd;
  logic [1:0] rxd;
  logic       crs_dv;

  logic [7:0] fmem [16];
  logic [3:0] head = '0;
  logic [3:0] tail = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign fifo_empty = (head == tail);
  assign fifo_data  = fmem[head];
  always @(posedge clk) if (fifo_rd) head <= head + 4'd1;

  rmii_rx_fmt u_rmii_rx_fmt (
    .clk_i (clk), .rst_ni (rst_n), .speed_10_i (speed_10),
    .carrier_i (carrier), .false_carrier_i (false_car), .symbol_err_i (sym_err),
    .fifo_empty_i (fifo_empty), .fifo_data_i (fifo_data), .fifo_rd_o (fifo_rd),
    .rxd_o (rxd), .crs_dv_o (crs_dv)
  );

  // {speed10, flip speed mid-frame, byte count, carrier-drop slot, bytes (byte0 low)}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h110000E4, 32'h3F963CA5, 32'h2400C35A,
    32'hD200009D, 32'hA600E871, 32'h03000000
  };

  task automatic report();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    fmem[tail] = d;
    tail = tail + 4'd1;
  endtask

  // checks one di-bit slot over all its falling edges; optionally drops carrier in it
  task automatic check_slot(input int len, input logic [1:0] er, input logic ec,
                            input string req, input bit drop);
    bit ok;
    logic [2:0] first;
    ok = 1'b1;
    first = '0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if ({crs_dv, rxd} !== {ec, er}) ok = 1'b0;
      if (c == 0) begin
        first = {crs_dv, rxd};
        if (drop) carrier = 1'b0;
      end
    end
    chk(ok, req, {5'd0, first}, {5'd0, ec, er});
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    report();
  end

  initial begin
    logic [31:0] vec;
    int nb, h, len, endslot;
    bit spd, flip;
    logic [1:0] er;
    logic ec;
    string tag;

    repeat (3) @(negedge clk);
    chk({crs_dv, rxd} === 3'b000, "R1 reset", {5'd0, crs_dv, rxd}, 8'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: queued data is not read while idle
    push(8'h77);
    repeat (5) @(negedge clk);
    chk(head != tail && {crs_dv, rxd} === 3'b000, "R1 idle",
        {3'd0, crs_dv, rxd, 2'(tail - head)}, 8'h01);
    tail = head;

    for (int v = 0; v < NV; v++) begin
      vec  = VEC[v];
      spd  = vec[31];
      flip = vec[30];
      nb   = int'(vec[29:28]);
      h    = int'(vec[27:24]);
      len  = spd ? 10 : 1;
      speed_10 = spd;
      @(negedge clk);
      for (int b = 0; b < nb; b++) push(vec[8*b +: 8]);
      carrier = 1'b1;
      check_slot(len, 2'b01, 1'b1, spd ? "R2 R5" : "R2", h == 1);
      if (flip) speed_10 = ~spd;
      endslot = ((4 * nb > h - 1) ? 4 * nb : h - 1) + 1;
      for (int n = 1; n <= endslot; n++) begin
        if (n == endslot) begin
          er = 2'b00; ec = 1'b0; tag = "R8";
        end else begin
          er = (n <= 4 * nb) ? vec[8*((n-1)/4) + 2*((n-1)%4) +: 2] : 2'b00;
          ec = (n < h) ? 1'b1 : 1'((n % 2) == 1);
          if (n >= h)           tag = "R7";
          else if (n > 4 * nb)  tag = "R9";
          else if (flip)        tag = "R6";
          else if (spd)         tag = "R5";
          else if (v == 1)      tag = "R4";
          else                  tag = "R3";
        end
        check_slot(len, er, ec, tag, (n == h - 1));
      end
      chk(head == tail, "R3 one pop per byte", {4'd0, head}, {4'd0, tail});
      speed_10 = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R10: false carrier at frame start
    push(8'h55);
    false_car = 1'b1;
    carrier = 1'b1;
    for (int s = 0; s < 4; s++) check_slot(1, 2'b10, 1'b1, "R10", s == 3);
    false_car = 1'b0;
    check_slot(1, 2'b00, 1'b0, "R10 end", 1'b0);
    chk(4'(tail - head) == 4'd1, "R10 no pop", {4'd0, 4'(tail - head)}, 8'h01);
    tail = head;
    @(negedge clk);

    // R11: symbol error in mid-frame
    push(8'h1B);
    push(8'hC6);
    carrier = 1'b1;
    check_slot(1, 2'b01, 1'b1, "R11 marker", 1'b0);
    check_slot(1, 2'b11, 1'b1, "R11 data", 1'b0);
    check_slot(1, 2'b10, 1'b1, "R11 data", 1'b0);
    sym_err = 1'b1;
    check_slot(1, 2'b10, 1'b1, "R11 err", 1'b0);
    sym_err = 1'b0;
    check_slot(1, 2'b10, 1'b1, "R11 err held", 1'b1);
    check_slot(1, 2'b00, 1'b0, "R11 end", 1'b0);
    chk(4'(tail - head) == 4'd1, "R11 no pop", {4'd0, 4'(tail - head)}, 8'h01);
    tail = head;
    @(negedge clk);

    // R1: asynchronous reset in mid-frame
    push(8'hF0);
    carrier = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({crs_dv, rxd} === 3'b000, "R1 async reset", {5'd0, crs_dv, rxd}, 8'h0);
    carrier = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tail = head;
    repeat (2) @(negedge clk);
    chk({crs_dv, rxd} === 3'b000, "R1 after reset", {5'd0, crs_dv, rxd}, 8'h0);

    report();
  end
endmodule